// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit services a cache read miss by assembling a full 32-byte line from a memory bus that moves only 8 bytes per transfer. When a miss is accepted, the unit asks memory first for the 8-byte chunk that holds the missing address. It then asks for the remaining chunks in wrap-around order. Each returned beat carries its chunk index and is stored in the matching slot of a fill buffer. As soon as the critical chunk arrives, its data is handed to the core on a one-cycle early-data port, so the core can restart before the line is complete. Once all four beats are present, the assembled line is written into the cache data array in a single strobe.

Only one fill can be outstanding at a time. While a fill is running, `busy` is high and a new miss is refused. Cache hits keep being granted throughout the fill, except in the single cycle in which the finished line takes the data array's write port.

The controller is a four-state machine. FILL_IDLE accepts a miss and moves to FILL_REQ (transition "accept"). FILL_REQ issues one request per chunk; when the fourth request is accepted it moves to FILL_WAIT ("requests done"). In FILL_WAIT, the arrival of the fourth beat moves it to FILL_WRITE ("line complete"). FILL_WRITE lasts one cycle and returns to FILL_IDLE ("retire"). Beats may arrive in FILL_REQ or in FILL_WAIT.

Top module: `cwf_fill_unit`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `early_valid` and `line_wr_en` are 0 and `miss_ready` is 1.
- R2: A miss is accepted in a cycle where `miss_valid` and `miss_ready` are both 1. `busy` is 1 from the next cycle on, and `miss_ready` stays 0 until the fill retires. A `miss_valid` raised during a fill is ignored and does not change the line address being requested.
- R3: A fill issues exactly four memory requests. The first carries `mem_req_chunk` equal to the accepted `miss_chunk`, which is byte-address bits [4:3] of the miss.
- R4: Request n (n = 0..3) carries chunk index (miss_chunk + n) mod 4, and every request carries the accepted line address on `mem_req_line`.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with the same chunk index in the next cycle.
- R6: In the cycle after a beat whose `mem_rsp_chunk` equals the critical chunk, `early_valid` is 1 for exactly one cycle, and `early_data` holds that beat's data. No other beat produces an early pulse.
- R7: Each beat is stored by its tag. In the line write, chunk k occupies `line_wr_data` bits [64k+63:64k].
- R8: `line_wr_en` is 1 for exactly one cycle, the cycle after the fourth beat, with `line_wr_addr` equal to the accepted line address. `busy` is 0 and `miss_ready` is 1 in the following cycle.
- R9: `hit_grant` equals `hit_valid`, both while idle and during a fill, except in the line-write cycle, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line_addr | input | 27 | Line address of the miss |
| miss_chunk | input | 2 | Chunk index of the missing word |
| miss_ready | output | 1 | Unit can accept a miss |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | 27 | Line address of the request |
| mem_req_chunk | output | 2 | Chunk index of the request |
| mem_rsp_valid | input | 1 | Returned beat valid |
| mem_rsp_chunk | input | 2 | Chunk index tag of the beat |
| mem_rsp_data | input | 64 | Beat data |
| hit_valid | input | 1 | Core hit access wants the data array |
| hit_grant | output | 1 | Hit access granted this cycle |
| early_valid | output | 1 | Critical chunk delivered to the core |
| early_data | output | 64 | Critical chunk data |
| line_wr_en | output | 1 | Line write strobe to the data array |
| line_wr_addr | output | 27 | Line address for the write |
| line_wr_data | output | 256 | Assembled line |
| busy | output | 1 | Fill in progress |

## Verification
Directed fills start at each chunk index 0 through 3, so the request order and the early pulse are seen both for a fill with no wrap and for fills that wrap at every point. Random fills vary the line address, data salt, request stalls and beat gaps. The stalls separate a request that holds its chunk from one that advances early. The gaps let beats arrive both before and after the last request, which tells the FILL_REQ and FILL_WAIT paths apart. Hits are held active during fills to show that grants continue under a miss and drop only in the write cycle, and miss requests are raised mid-fill to show they are refused.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_REQ   = 2'd1,
        FILL_WAIT  = 2'd2,
        FILL_WRITE = 2'd3
    } fill_state_e;
endpackage

// File: rtl/cwf_wrap_ctr.sv
// Wrapping chunk sequencer: index = base + count (mod 2^IDX_W).
module cwf_wrap_ctr #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx  = base + cnt_q;
    assign last = (cnt_q == {IDX_W{1'b1}});
endmodule

// File: rtl/cwf_fill_buffer.sv
// Fill buffer: one slot per chunk, written by the beat's tag.
module cwf_fill_buffer #(
    parameter int NUM_BEATS = 4,
    parameter int BEAT_W    = 64,
    localparam int IDX_W    = $clog2(NUM_BEATS),
    localparam int LINE_W   = NUM_BEATS * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BEAT_W-1:0] wr_data,
    output logic [LINE_W-1:0] line
);
    for (genvar g = 0; g < NUM_BEATS; g++) begin : g_slot
        logic [BEAT_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign line[g*BEAT_W +: BEAT_W] = slot_q;
    end
endmodule

// File: rtl/cwf_fill_ctrl.sv
// Fill controller: state machine, beat counting and early restart.
module cwf_fill_ctrl
    import cwf_pkg::*;
#(
    parameter int NUM_BEATS = 4,
    parameter int BEAT_W    = 64,
    parameter int LINE_AW   = 27,
    localparam int IDX_W    = $clog2(NUM_BEATS),
    localparam int CNT_W    = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line_addr,
    input  logic [IDX_W-1:0]   miss_chunk,
    output logic               miss_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic               req_last,
    input  logic               mem_rsp_valid,
    input  logic [IDX_W-1:0]   mem_rsp_chunk,
    input  logic [BEAT_W-1:0]  mem_rsp_data,
    input  logic               hit_valid,
    output logic               hit_grant,
    output logic               early_valid,
    output logic [BEAT_W-1:0]  early_data,
    output logic               line_wr_en,
    output logic [LINE_AW-1:0] line_q,
    output logic [IDX_W-1:0]   crit_q,
    output logic               miss_fire,
    output logic               req_fire,
    output logic               rsp_fire,
    output logic               busy
);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(NUM_BEATS - 1);

    fill_state_e state_q, state_d;
    logic [CNT_W-1:0]  rsp_cnt_q;
    logic              early_valid_q;
    logic [BEAT_W-1:0] early_data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE:  if (miss_fire) state_d = FILL_REQ;
            FILL_REQ:   if (req_fire && req_last) state_d = FILL_WAIT;
            FILL_WAIT:  if (rsp_fire && (rsp_cnt_q == LAST_BEAT)) state_d = FILL_WRITE;
            FILL_WRITE: state_d = FILL_IDLE;
            default:    state_d = FILL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        miss_ready    = 1'b0;
        mem_req_valid = 1'b0;
        line_wr_en    = 1'b0;
        busy          = 1'b1;
        unique case (state_q)
            FILL_IDLE: begin
                miss_ready = 1'b1;
                busy       = 1'b0;
            end
            FILL_REQ:   mem_req_valid = 1'b1;
            FILL_WAIT:  ;
            FILL_WRITE: line_wr_en = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign miss_fire = miss_valid && miss_ready;
    assign req_fire  = mem_req_valid && mem_req_ready;
    assign rsp_fire  = mem_rsp_valid &&
                       ((state_q == FILL_REQ) || (state_q == FILL_WAIT));
    assign hit_grant = hit_valid && !line_wr_en;

    // miss context and beat count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= '0;
            crit_q    <= '0;
            rsp_cnt_q <= '0;
        end else if (miss_fire) begin
            line_q    <= miss_line_addr;
            crit_q    <= miss_chunk;
            rsp_cnt_q <= '0;
        end else if (rsp_fire) begin
            rsp_cnt_q <= rsp_cnt_q + 1'b1;
        end
    end

    // early restart: forward the critical beat one cycle after it lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_valid_q <= 1'b0;
            early_data_q  <= '0;
        end else begin
            early_valid_q <= rsp_fire && (mem_rsp_chunk == crit_q);
            if (rsp_fire && (mem_rsp_chunk == crit_q)) begin
                early_data_q <= mem_rsp_data;
            end
        end
    end

    assign early_valid = early_valid_q;
    assign early_data  = early_data_q;
endmodule

// File: rtl/cwf_fill_unit.sv
module cwf_fill_unit #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8,
    localparam int NUM_BEATS = LINE_BYTES / BEAT_BYTES,
    localparam int IDX_W     = $clog2(NUM_BEATS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_AW   = ADDR_W - OFF_W,
    localparam int BEAT_W    = BEAT_BYTES * 8,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line_addr,
    input  logic [IDX_W-1:0]   miss_chunk,
    output logic               miss_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LINE_AW-1:0] mem_req_line,
    output logic [IDX_W-1:0]   mem_req_chunk,
    input  logic               mem_rsp_valid,
    input  logic [IDX_W-1:0]   mem_rsp_chunk,
    input  logic [BEAT_W-1:0]  mem_rsp_data,
    input  logic               hit_valid,
    output logic               hit_grant,
    output logic               early_valid,
    output logic [BEAT_W-1:0]  early_data,
    output logic               line_wr_en,
    output logic [LINE_AW-1:0] line_wr_addr,
    output logic [LINE_W-1:0]  line_wr_data,
    output logic               busy
);
    logic [LINE_AW-1:0] line_q;
    logic [IDX_W-1:0]   crit_q;
    logic               miss_fire, req_fire, rsp_fire, req_last;

    cwf_fill_ctrl #(
        .NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W), .LINE_AW(LINE_AW)
    ) u_ctrl (
        .clk, .rst_n,
        .miss_valid, .miss_line_addr, .miss_chunk, .miss_ready,
        .mem_req_valid, .mem_req_ready, .req_last,
        .mem_rsp_valid, .mem_rsp_chunk, .mem_rsp_data,
        .hit_valid, .hit_grant,
        .early_valid, .early_data,
        .line_wr_en, .line_q, .crit_q,
        .miss_fire, .req_fire, .rsp_fire, .busy
    );

    cwf_wrap_ctr #(.IDX_W(IDX_W)) u_order (
        .clk, .rst_n,
        .load (miss_fire),
        .step (req_fire),
        .base (crit_q),
        .idx  (mem_req_chunk),
        .last (req_last)
    );

    cwf_fill_buffer #(.NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W)) u_fbuf (
        .clk, .rst_n,
        .wr_en   (rsp_fire),
        .wr_idx  (mem_rsp_chunk),
        .wr_data (mem_rsp_data),
        .line    (line_wr_data)
    );

    assign mem_req_line = line_q;
    assign line_wr_addr = line_q;
endmodule

// File: rtl/cwf_fill_checker.sv
module cwf_fill_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       miss_valid,
    input logic       miss_ready,
    input logic       mem_req_valid,
    input logic       mem_req_ready,
    input logic [1:0] mem_req_chunk,
    input logic       hit_grant,
    input logic       early_valid,
    input logic       line_wr_en,
    input logic       busy
);
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> busy);

    assert_req_in_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_chunk)));

    assert_early_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |=> !early_valid);

    assert_early_in_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> busy);

    assert_write_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_en |=> (!line_wr_en && !busy));

    assert_write_blocks_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_en |-> !hit_grant);
endmodule

bind cwf_fill_unit cwf_fill_checker u_fill_checker (
    .clk, .rst_n, .miss_valid, .miss_ready, .mem_req_valid, .mem_req_ready,
    .mem_req_chunk, .hit_grant, .early_valid, .line_wr_en, .busy
);

// File: tb/tb_cwf_fill_unit.sv
`timescale 1ns/1ps
module tb_cwf_fill_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [26:0]  miss_line_addr = '0;
    logic [1:0]   miss_chunk = '0;
    logic         miss_ready;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [26:0]  mem_req_line;
    logic [1:0]   mem_req_chunk;
    logic         mem_rsp_valid = 1'b0;
    logic [1:0]   mem_rsp_chunk = '0;
    logic [63:0]  mem_rsp_data = '0;
    logic         hit_valid = 1'b0;
    logic         hit_grant;
    logic         early_valid;
    logic [63:0]  early_data;
    logic         line_wr_en;
    logic [26:0]  line_wr_addr;
    logic [255:0] line_wr_data;
    logic         busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cwf_fill_unit dut (.*);

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_val(input logic [26:0] line,
                                             input logic [1:0] chunk,
                                             input logic [31:0] salt);
        return {salt ^ {5'd0, line}, 8'hA5, 22'd0, chunk};
    endfunction

    task automatic run_fill(input logic [26:0] line, input logic [1:0] crit,
                            input logic [31:0] salt, input bit hit_on, input bit rnd);
        logic [255:0] exp_line = '0;
        @(negedge clk);
        check(miss_ready == 1'b1, "R2 ready before miss", 256'(miss_ready), 256'd1);
        miss_valid = 1'b1; miss_line_addr = line; miss_chunk = crit; hit_valid = hit_on;
        @(negedge clk);
        miss_valid = 1'b0;
        check(busy && !miss_ready, "R2 busy after accept", {busy, miss_ready}, 256'b10);
        for (int n = 0; n < 4; n++) begin
            logic [1:0] exp_c = crit + 2'(n);
            int stall = rnd ? int'($urandom_range(0, 2)) : 0;
            int gap   = rnd ? int'($urandom_range(0, 2)) : 0;
            logic [63:0] d = beat_val(line, exp_c, salt);
            check(mem_req_valid && mem_req_chunk == exp_c,
                  (n == 0) ? "R3 first request is critical chunk" : "R4 wrapped chunk order",
                  {mem_req_valid, mem_req_chunk}, {1'b1, exp_c});
            check(mem_req_line == line, "R4 request line address",
                  256'(mem_req_line), 256'(line));
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(mem_req_valid && mem_req_chunk == exp_c, "R5 request held",
                      {mem_req_valid, mem_req_chunk}, {1'b1, exp_c});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int g = 0; g < gap; g++) begin
                miss_valid = 1'b1; miss_line_addr = ~line; miss_chunk = ~crit;
                check(hit_grant == hit_on, "R9 hit granted under miss",
                      256'(hit_grant), 256'(hit_on));
                check(!miss_ready, "R2 miss refused while busy", 256'(miss_ready), 256'd0);
                @(negedge clk);
                miss_valid = 1'b0;
            end
            mem_rsp_valid = 1'b1; mem_rsp_chunk = exp_c; mem_rsp_data = d;
            exp_line[exp_c*64 +: 64] = d;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (n == 0)
                check(early_valid && early_data == d, "R6 early data after critical beat",
                      {early_valid, early_data}, {1'b1, d});
            else
                check(!early_valid, "R6 no early pulse for other beats",
                      256'(early_valid), 256'd0);
            if (n < 3)
                check(!line_wr_en, "R8 no write before last beat", 256'(line_wr_en), 256'd0);
        end
        check(line_wr_en && busy && line_wr_addr == line, "R8 line write strobe",
              {line_wr_en, busy, line_wr_addr}, {1'b1, 1'b1, line});
        check(line_wr_data == exp_line, "R7 assembled line", line_wr_data, exp_line);
        check(hit_grant == 1'b0, "R9 hit blocked in write cycle", 256'(hit_grant), 256'd0);
        @(negedge clk);
        check(!line_wr_en && !busy && miss_ready, "R8 retire after write",
              {line_wr_en, busy, miss_ready}, 256'b001);
        check(hit_grant == hit_on, "R9 hit granted when idle", 256'(hit_grant), 256'(hit_on));
        hit_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && miss_ready && !mem_req_valid && !early_valid && !line_wr_en,
              "R1 reset state",
              {busy, miss_ready, mem_req_valid, early_valid, line_wr_en}, 256'b01000);
        rst_n = 1'b1;
        // directed: every starting chunk index (byte offset bits [4:3])
        run_fill(27'h0000004, 2'd2, 32'h1111_0000, 1'b1, 1'b0); // byte 0x95 -> chunk 2
        run_fill(27'h0000123, 2'd0, 32'h2222_0000, 1'b0, 1'b0);
        run_fill(27'h7FFFFFF, 2'd3, 32'h3333_0000, 1'b1, 1'b0);
        run_fill(27'h2AAAAAA, 2'd1, 32'h4444_0000, 1'b0, 1'b0);
        // random fills
        for (int i = 0; i < 12; i++) begin
            run_fill(27'($urandom), 2'($urandom), $urandom, 1'($urandom), 1'b1);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule